// File: doc/BRIEF.md
# Front-End Control Bus Frame Receiver

This block is the receive half of a slave on a two-wire front-end control bus. One line is a bus clock and the other a data line. Both lines are brought into a faster system clock through a synchroniser. The receiver watches them for the start condition that opens every command sequence. It then shifts in a 13-bit command frame: a 4-bit slave address, an 8-bit command and a parity bit. It checks the frame's odd parity and compares the address against a configured identity.

When the command frame is accepted, each later 9-bit frame becomes one payload byte, tagged with its position after the command. Downstream logic uses that position to tell address frames from data frames. A frame of nine zero bits is reported as a no-response frame and not as a parity error. A start condition seen at any point abandons whatever was in progress.

Top module: `fe_frame_rx`

## Requirements
- R1: While reset is asserted and after it is released, with no bus traffic, all three strobes (`cmd_valid_o`, `cmd_err_o`, `pay_valid_o`) stay low.
- R2: A start condition is a rise of the data line followed later by a fall of the data line, with the bus clock low the whole time. Data edges while the bus clock is high do not restart the receiver.
- R3: After a start condition, data is sampled on each falling edge of the bus clock, most significant bit first. The 13-bit command frame is address bits [12:9], command bits [8:1] and parity bit [0]. An accepted frame gives a one-cycle `cmd_valid_o` with `cmd_addr_o` and `cmd_byte_o`.
- R4: A command frame whose count of ones is even gives a one-cycle `cmd_err_o` and no `cmd_valid_o`. Every frame after it is discarded until the next start condition.
- R5: A command frame with good parity whose address differs from `slave_id_i` gives no strobe, and the frames after it are ignored until the next start condition.
- R6: After an accepted command frame, every 9 sampled bits form one frame: payload bits [8:1] and parity bit [0]. Each frame gives a one-cycle `pay_valid_o` with the payload on `pay_byte_o`.
- R7: `pay_index_o` is 0 for the first frame after the command frame and rises by one per frame. It stays at its all-ones maximum (15 by default) once reached.
- R8: A payload frame with an even count of ones that is not all zero sets `pay_perr_o` with its `pay_valid_o`. An odd count clears it.
- R9: A payload frame of nine zero bits sets `pay_nrf_o` and clears `pay_perr_o`, with `pay_byte_o` equal to 0.
- R10: A start condition in the middle of a command or payload frame discards the partial frame. The following bits are taken as a new command frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock line, asynchronous |
| bus_dat_i | input | 1 | Bus data line, asynchronous |
| slave_id_i | input | 4 | Configured slave address |
| cmd_valid_o | output | 1 | Accepted command frame strobe |
| cmd_err_o | output | 1 | Command frame parity error strobe |
| cmd_addr_o | output | 4 | Address of the last accepted command frame |
| cmd_byte_o | output | 8 | Command byte of the last accepted command frame |
| pay_valid_o | output | 1 | Payload frame strobe |
| pay_byte_o | output | 8 | Payload byte |
| pay_index_o | output | 4 | Frame position after the command frame |
| pay_perr_o | output | 1 | Payload parity error, valid with the strobe |
| pay_nrf_o | output | 1 | No-response frame flag, valid with the strobe |

## Verification
The bench restarts the receiver in the middle of both a command frame and a payload frame. A design that kept the partial bits would report shifted bytes or wrong indices. It pulses the data line while the bus clock is high inside a payload frame. A receiver that ignored the clock level there would restart and lose the payload. An all-zero frame and an even-parity frame are both sent, which exposes a design that merges the no-response flag with the parity error. A run of eighteen frames checks that the index saturates instead of wrapping to zero. Address mismatches and command parity errors are each followed by frames that must raise no strobe.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

    localparam int FE_ADDR_W      = 4;
    localparam int FE_BYTE_W      = 8;
    localparam int FE_IDX_W       = 4;
    localparam int FE_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/fe_line_events.sv
module fe_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdat_i,
    output logic sclk_fall_o,
    output logic seq_start_o
);

    typedef struct packed {
        logic sclk;
        logic sdat;
        logic armed;
    } ev_regs_t;

    ev_regs_t ev_d, ev_q;
    logic     dat_rise, dat_fall;

    always_comb begin
        ev_d      = ev_q;
        ev_d.sclk = sclk_i;
        ev_d.sdat = sdat_i;
        dat_rise  = sdat_i & ~ev_q.sdat;
        dat_fall  = ~sdat_i & ev_q.sdat;
        if (sclk_i)
            ev_d.armed = 1'b0;
        else if (dat_rise)
            ev_d.armed = 1'b1;
        else if (dat_fall)
            ev_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign sclk_fall_o = ev_q.sclk & ~sclk_i;
    assign seq_start_o = ev_q.armed & dat_fall & ~sclk_i;

endmodule

// File: rtl/fe_odd_parity.sv
module fe_odd_parity #(
    parameter int W = 9
) (
    input  logic [W-1:0] word_i,
    output logic         odd_o
);

    logic [W:0] acc;

    assign acc[0] = 1'b0;
    generate
        for (genvar i = 0; i < W; i++) begin : g_fold
            assign acc[i+1] = acc[i] ^ word_i[i];
        end
    endgenerate

    assign odd_o = acc[W];

endmodule

// File: rtl/fe_frame_rx.sv
module fe_frame_rx
    import fe_rx_pkg::*;
#(
    parameter int ADDR_W      = FE_ADDR_W,
    parameter int BYTE_W      = FE_BYTE_W,
    parameter int IDX_W       = FE_IDX_W,
    parameter int SYNC_STAGES = FE_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_i,
    input  logic              bus_dat_i,
    input  logic [ADDR_W-1:0] slave_id_i,
    output logic              cmd_valid_o,
    output logic              cmd_err_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [BYTE_W-1:0] cmd_byte_o,
    output logic              pay_valid_o,
    output logic [BYTE_W-1:0] pay_byte_o,
    output logic [IDX_W-1:0]  pay_index_o,
    output logic              pay_perr_o,
    output logic              pay_nrf_o
);

    localparam int CMD_BITS   = ADDR_W + BYTE_W + 1;
    localparam int FRAME_BITS = BYTE_W + 1;
    localparam int CNT_W      = $clog2(CMD_BITS);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_MAX    = {IDX_W{1'b1}};

    typedef struct packed {
        rx_state_e          st;
        logic [CMD_BITS-2:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic               cmd_v;
        logic               cmd_e;
        logic [ADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]  cmd;
        logic               pay_v;
        logic [BYTE_W-1:0]  pay;
        logic [IDX_W-1:0]   pay_idx;
        logic               perr;
        logic               nrf;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic [1:0]            sync_lines;
    logic                  sclk_s, sdat_s;
    logic                  sclk_fall, seq_start;
    logic [CMD_BITS-1:0]   cmd_word;
    logic [FRAME_BITS-1:0] pay_word;
    logic                  cmd_odd, pay_odd, pay_zero;

    fe_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_clk_i, bus_dat_i}),
        .sync_o  (sync_lines)
    );

    assign sclk_s = sync_lines[1];
    assign sdat_s = sync_lines[0];

    fe_line_events u_events (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_s),
        .sdat_i      (sdat_s),
        .sclk_fall_o (sclk_fall),
        .seq_start_o (seq_start)
    );

    assign cmd_word = {r_q.sh, sdat_s};
    assign pay_word = cmd_word[FRAME_BITS-1:0];
    assign pay_zero = (pay_word == '0);

    fe_odd_parity #(.W(CMD_BITS)) u_cmd_par (
        .word_i (cmd_word),
        .odd_o  (cmd_odd)
    );

    fe_odd_parity #(.W(FRAME_BITS)) u_pay_par (
        .word_i (pay_word),
        .odd_o  (pay_odd)
    );

    always_comb begin
        r_d       = r_q;
        r_d.cmd_v = 1'b0;
        r_d.cmd_e = 1'b0;
        r_d.pay_v = 1'b0;

        if (seq_start) begin
            r_d.st  = ST_CMD;
            r_d.cnt = '0;
            r_d.sh  = '0;
        end else if (sclk_fall) begin
            unique case (r_q.st)
                ST_CMD: begin
                    r_d.sh = cmd_word[CMD_BITS-2:0];
                    if (r_q.cnt == CMD_LAST) begin
                        r_d.cnt = '0;
                        if (!cmd_odd) begin
                            r_d.cmd_e = 1'b1;
                            r_d.st    = ST_IDLE;
                        end else if (cmd_word[CMD_BITS-1 -: ADDR_W] == slave_id_i) begin
                            r_d.cmd_v = 1'b1;
                            r_d.addr  = cmd_word[CMD_BITS-1 -: ADDR_W];
                            r_d.cmd   = cmd_word[BYTE_W:1];
                            r_d.idx   = '0;
                            r_d.st    = ST_DATA;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    r_d.sh = cmd_word[CMD_BITS-2:0];
                    if (r_q.cnt == FRAME_LAST) begin
                        r_d.cnt     = '0;
                        r_d.pay_v   = 1'b1;
                        r_d.pay     = pay_word[BYTE_W:1];
                        r_d.pay_idx = r_q.idx;
                        r_d.nrf     = pay_zero;
                        r_d.perr    = ~pay_odd & ~pay_zero;
                        if (r_q.idx != IDX_MAX)
                            r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: begin
                    r_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_valid_o = r_q.cmd_v;
    assign cmd_err_o   = r_q.cmd_e;
    assign cmd_addr_o  = r_q.addr;
    assign cmd_byte_o  = r_q.cmd;
    assign pay_valid_o = r_q.pay_v;
    assign pay_byte_o  = r_q.pay;
    assign pay_index_o = r_q.pay_idx;
    assign pay_perr_o  = r_q.perr & r_q.pay_v;
    assign pay_nrf_o   = r_q.nrf & r_q.pay_v;

endmodule

// File: rtl/fe_frame_rx_chk.sv
module fe_frame_rx_chk #(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] slave_id_i,
    input logic              cmd_valid_o,
    input logic              cmd_err_o,
    input logic [ADDR_W-1:0] cmd_addr_o,
    input logic              pay_valid_o,
    input logic [BYTE_W-1:0] pay_byte_o,
    input logic [IDX_W-1:0]  pay_index_o,
    input logic              pay_perr_o,
    input logic              pay_nrf_o
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid_o, cmd_err_o, pay_valid_o})); // R3

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R3

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_o |=> !cmd_err_o && !cmd_valid_o); // R4

    AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_addr_o == slave_id_i); // R5

    AST_PAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid_o |=> !pay_valid_o); // R6

    AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> $stable(pay_index_o)); // R7

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pay_valid_o |-> !pay_perr_o && !pay_nrf_o); // R8

    AST_NRF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pay_nrf_o |-> !pay_perr_o && pay_byte_o == '0); // R9

endmodule

bind fe_frame_rx fe_frame_rx_chk #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slave_id_i  (slave_id_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_err_o   (cmd_err_o),
    .cmd_addr_o  (cmd_addr_o),
    .pay_valid_o (pay_valid_o),
    .pay_byte_o  (pay_byte_o),
    .pay_index_o (pay_index_o),
    .pay_perr_o  (pay_perr_o),
    .pay_nrf_o   (pay_nrf_o)
);

// File: tb/fe_frame_rx_bench.sv
`timescale 1ns/1ps
module fe_frame_rx_bench;

    localparam int HALF    = 6;
    localparam int IDX_TOP = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_clk = 1'b0;
    logic       bus_dat = 1'b0;
    logic [3:0] slave_id = 4'hA;
    logic       cmd_valid, cmd_err, pay_valid, pay_perr, pay_nrf;
    logic [3:0] cmd_addr, pay_index;
    logic [7:0] cmd_byte, pay_byte;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    string cur_tag = "R1";

    typedef struct {
        int kind;
        int addr;
        int cmd;
        int byt;
        int idx;
        bit perr;
        bit nrf;
    } ev_t;

    ev_t exp_q[$];
    bit  active  = 0;
    int  mdl_idx = 0;

    always #10 clk = ~clk;

    fe_frame_rx u_fe_frame_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_clk_i   (bus_clk),
        .bus_dat_i   (bus_dat),
        .slave_id_i  (slave_id),
        .cmd_valid_o (cmd_valid),
        .cmd_err_o   (cmd_err),
        .cmd_addr_o  (cmd_addr),
        .cmd_byte_o  (cmd_byte),
        .pay_valid_o (pay_valid),
        .pay_byte_o  (pay_byte),
        .pay_index_o (pay_index),
        .pay_perr_o  (pay_perr),
        .pay_nrf_o   (pay_nrf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model on the output side: every strobe is matched against the queue.
    always @(negedge clk) begin
        if (rst_n && (cmd_valid || cmd_err || pay_valid)) begin
            if (exp_q.size() == 0) begin
                check(0, cur_tag, {cmd_valid, cmd_err, pay_valid}, 0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                if (e.kind == 0) begin
                    check(cmd_valid, "R3", {cmd_valid, cmd_err, pay_valid}, 4);
                    check(cmd_addr == e.addr[3:0], "R3", cmd_addr, e.addr);
                    check(cmd_byte == e.cmd[7:0], "R3", cmd_byte, e.cmd);
                end else if (e.kind == 1) begin
                    check(cmd_err, "R4", {cmd_valid, cmd_err, pay_valid}, 2);
                end else begin
                    check(pay_valid, "R6", {cmd_valid, cmd_err, pay_valid}, 1);
                    check(pay_byte == e.byt[7:0], "R6", pay_byte, e.byt);
                    check(pay_index == e.idx[3:0], "R7", pay_index, e.idx);
                    check(pay_perr == e.perr, "R8", pay_perr, e.perr);
                    check(pay_nrf == e.nrf, "R9", pay_nrf, e.nrf);
                end
            end
        end
    end

    task automatic half_wait();
        repeat (HALF) @(posedge clk);
    endtask

    task automatic send_bit(input bit b, input bit glitch);
        bus_clk <= 1'b1;
        bus_dat <= b;
        half_wait();
        if (glitch) begin
            bus_dat <= 1'b1;
            half_wait();
            bus_dat <= 1'b0;
            half_wait();
        end
        bus_clk <= 1'b0;
        half_wait();
    endtask

    task automatic seq_start();
        bus_clk <= 1'b0;
        bus_dat <= 1'b0;
        half_wait();
        bus_dat <= 1'b1;
        half_wait();
        bus_dat <= 1'b0;
        half_wait();
        active = 0;
    endtask

    task automatic send_cmd(input int addr, input int cmd, input bit good_par);
        logic [11:0] body;
        logic [12:0] frame;
        ev_t e;
        body  = {addr[3:0], cmd[7:0]};
        frame = {body, good_par ? ~^body : ^body};
        if (!good_par) begin
            e = '{1, 0, 0, 0, 0, 0, 0};
            exp_q.push_back(e);
        end else if (addr[3:0] == slave_id) begin
            e = '{0, addr, cmd, 0, 0, 0, 0};
            exp_q.push_back(e);
            active  = 1;
            mdl_idx = 0;
        end
        for (int i = 12; i >= 0; i--) send_bit(frame[i], 0);
    endtask

    task automatic send_raw9(input logic [8:0] w, input bit glitch_first);
        ev_t e;
        bit  nrf, perr;
        nrf  = (w == 9'd0);
        perr = !nrf && ($countones(w) % 2 == 0);
        if (active) begin
            e = '{2, 0, 0, int'(w[8:1]), mdl_idx, perr, nrf};
            exp_q.push_back(e);
            if (mdl_idx < IDX_TOP) mdl_idx++;
        end
        for (int i = 8; i >= 0; i--) send_bit(w[i], glitch_first && i == 8);
    endtask

    task automatic send_pay(input int b);
        send_raw9({b[7:0], ~^b[7:0]}, 0);
    endtask

    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) send_bit(i[0], 0);
    endtask

    task automatic drain(input string tag);
        repeat (4 * HALF) @(posedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!cmd_valid && !cmd_err && !pay_valid, "R1", {cmd_valid, cmd_err, pay_valid}, 0);
        rst_n <= 1'b1;
        repeat (10) @(negedge clk);
        check(!cmd_valid && !cmd_err && !pay_valid, "R1", {cmd_valid, cmd_err, pay_valid}, 0);

        // R3 R6 R7: accepted command and plain payloads
        cur_tag = "R3";
        seq_start();
        send_cmd(4'hA, 8'h3C, 1);
        send_pay(8'h12);
        send_pay(8'hFF);
        send_pay(8'h00);
        drain("R6");

        // R8: even-parity payload; R9: all-zero frame
        cur_tag = "R8";
        send_raw9({8'h55, 1'b0}, 0);
        send_raw9(9'd0, 0);
        send_pay(8'h81);
        drain("R9");

        // R4: command parity error discards the sequence
        cur_tag = "R4";
        seq_start();
        send_cmd(4'hA, 8'h5A, 0);
        send_pay(8'h11);
        send_pay(8'h22);
        drain("R4");

        // R5: address mismatch ignores frames, next start recovers
        cur_tag = "R5";
        seq_start();
        send_cmd(4'h5, 8'h01, 1);
        send_pay(8'h33);
        send_pay(8'h44);
        drain("R5");
        seq_start();
        send_cmd(4'hA, 8'hC3, 1);
        send_pay(8'h66);
        drain("R5");

        // R10: restart inside a payload frame and inside a command frame
        cur_tag = "R10";
        seq_start();
        send_cmd(4'hA, 8'h70, 1);
        send_pay(8'h01);
        send_partial(4);
        seq_start();
        send_partial(5);
        seq_start();
        send_cmd(4'hA, 8'h0F, 1);
        send_pay(8'hA5);
        drain("R10");

        // R2: data edges with the bus clock high are not a start
        cur_tag = "R2";
        seq_start();
        send_cmd(4'hA, 8'h99, 1);
        send_raw9({8'h34, ~^8'h34}, 1);
        send_pay(8'h56);
        drain("R2");

        // R7: index saturates at its maximum
        cur_tag = "R7";
        seq_start();
        send_cmd(4'hA, 8'hE1, 1);
        for (int k = 0; k < 18; k++) send_pay(k * 7 + 3);
        drain("R7");

        // R5: new configured identity
        cur_tag = "R5";
        slave_id <= 4'h3;
        half_wait();
        seq_start();
        send_cmd(4'hA, 8'h10, 1);
        send_pay(8'h20);
        seq_start();
        send_cmd(4'h3, 8'h42, 1);
        send_pay(8'hBE);
        drain("R5");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule